// File: doc/BRIEF.md
# Sleep Mode and Clock-Gating Controller

This block sits between a small processor core and its clock tree. When the core issues a sleep request while the sleep-enable input is set, the controller takes a three-bit mode code and the asynchronous-timer select, and samples the start-up length. It then parks the core in one of five low-power modes. The modes are idle, quiet-ADC, power-down, power-save and standby. For the mode in force it drives registered enables for five clock domains and for the main and timer oscillators.

While asleep it watches synchronised wake sources through a per-mode filter. The sources are the external interrupt lines, a serial address match, the asynchronous timer, ADC completion, other I/O interrupts and a reset request. After a wake it runs an oscillator start-up count, then a fixed halt of four cycles. It then returns the core to running and emits a one-cycle pulse that says whether to resume after an interrupt or to restart through the reset path. Memory and register contents are never touched. The controller only gates clocks.

Top module: `slp_clkgate_ctrl`

## Requirements
- R1: A sleep request taken while `sleep_en` is 0 is ignored: `core_halt` stays 0 and every clock enable keeps its running value.
- R2: `mode_sel` codes are 000 idle, 001 quiet-ADC, 010 power-down, 011 power-save and 110 standby. A request with code 100, 101 or 111 is ignored and the core keeps running.
- R3: `clk_en` bit order is [0] CPU, [1] flash, [2] I/O, [3] ADC, [4] async timer. Running and halt enable the first four, with bit 4 equal to the async select. Idle stops bits 0 and 1. Quiet-ADC stops bits 0 to 2. Power-save keeps only bit 4, and only if the async select was latched. Power-down and standby stop all five.
- R4: `osc_main_en` is 0 in power-down and power-save sleep and 1 otherwise, including the start-up count. `osc_tmr_en` follows `clk_en[4]`.
- R5: Wake sources per mode:
  - Idle accepts every source.
  - Quiet-ADC accepts external, serial match, ADC, and the timer when async is latched.
  - Power-save accepts external, serial match, and the timer when async is latched.
  - Power-down and standby accept external and serial match only.
- R6: Outside idle, an external line wakes only when its `ext_level` bit is 1 (level type). Edge-type lines are ignored.
- R7: The async select and the mode are latched when sleep starts. Later changes to `mode_sel`, `async_tmr_sel`, `startup_len` or `sleep_req` during sleep have no effect.
- R8: Idle and quiet-ADC use no start-up cycles. Standby uses a fixed 6. Power-down and power-save use the latched `startup_len`, and a value of 0 means none. The halt always lasts 4 cycles with `core_halt` 1 and all clocks running.
- R9: Leaving halt raises exactly one of `wake_irq` or `wake_reset` for one cycle, in the first running cycle.
- R10: A reset request seen during sleep, start-up or halt wakes the core and makes the final pulse `wake_reset`. It takes priority over any interrupt.
- R11: Every wake input passes two flip-flops. A source raised before edge k moves the state at edge k+2. In idle, `wake_irq` becomes visible after edge k+6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en | input | 1 | Sleep arming bit |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| mode_sel | input | 3 | Sleep mode code |
| async_tmr_sel | input | 1 | Asynchronous timer clocked from its own oscillator |
| startup_len | input | STARTUP_W | Oscillator start-up cycles for power-down and power-save |
| ext_irq | input | N_EXT | External interrupt requests (asynchronous) |
| ext_level | input | N_EXT | Per-line type, 1 = level |
| twi_match | input | 1 | Serial-bus address match request |
| tmr_async_irq | input | 1 | Asynchronous timer interrupt request |
| adc_irq | input | 1 | ADC conversion done request |
| io_irq | input | 1 | Any other I/O interrupt request |
| rst_req | input | 1 | Reset request |
| clk_en | output | 5 | Clock domain enables |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_tmr_en | output | 1 | Timer oscillator enable |
| core_halt | output | 1 | Core is asleep or waking |
| wake_irq | output | 1 | Resume pulse for interrupt service |
| wake_reset | output | 1 | Restart pulse for the reset path |

## Verification
Each mode is entered and offered first the sources its filter must reject, then one it accepts. This separates a correct wake matrix from one that is too open or too closed, and tells edge-type from level-type external lines. Start-up lengths of zero, a programmed value and the fixed standby count show whether the count source follows the latched mode. A reset request is applied alone, together with an interrupt, and late during the halt, to show that reset wins whenever it arrives. Changes to mode, timer select and length while asleep check that only the values at entry count.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_SLEEP   = 2'd1,
      ST_STARTUP = 2'd2,
      ST_HALT    = 2'd3
   } slp_state_e;

   // mode codes: the core writes these, so the values are fixed
   typedef enum logic [2:0] {
      MD_IDLE   = 3'b000,
      MD_QADC   = 3'b001,
      MD_PDOWN  = 3'b010,
      MD_PSAVE  = 3'b011,
      MD_STBY   = 3'b110
   } slp_mode_e;

   typedef enum logic [1:0] {
      SU_NONE  = 2'd0,
      SU_FIXED = 2'd1,
      SU_PROG  = 2'd2
   } slp_su_e;

   localparam int unsigned NUM_DOM   = 5;
   localparam int unsigned DOM_CPU   = 0;
   localparam int unsigned DOM_FLASH = 1;
   localparam int unsigned DOM_IO    = 2;
   localparam int unsigned DOM_ADC   = 3;
   localparam int unsigned DOM_ASY   = 4;

   // number of single-bit wake sources beside the external lines
   localparam int unsigned NUM_SOLO  = 5;

   typedef struct packed {
      logic                tmr_osc;
      logic                main_osc;
      logic [NUM_DOM-1:0]  dom;
   } slp_gate_t;

endpackage

// File: rtl/slp_wake_sync.sv
module slp_wake_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   initial assert (STAGES >= 2) else $fatal(1, "slp_wake_sync: STAGES must be at least 2");
   initial assert (WIDTH >= 1)  else $fatal(1, "slp_wake_sync: WIDTH must be at least 1");

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
   import slp_pkg::*;
#(
   parameter int unsigned N_EXT = 2
) (
   input  logic [2:0]       mode,
   input  logic             async_sel,
   input  logic [N_EXT-1:0] ext_level,
   input  logic [N_EXT-1:0] wk_ext,
   input  logic             wk_twi,
   input  logic             wk_tmr,
   input  logic             wk_adc,
   input  logic             wk_io,
   output logic             mode_ok,
   output logic             wake_hit,
   output slp_su_e          su_kind,
   output slp_gate_t        sleep_gate
);

   logic [N_EXT-1:0] ext_lvl_hit;
   logic             ext_any, ext_lvl;

   // per-line level qualification
   for (genvar i = 0; i < N_EXT; i++) begin : g_ext
      assign ext_lvl_hit[i] = wk_ext[i] & ext_level[i];
   end

   assign ext_any = |wk_ext;
   assign ext_lvl = |ext_lvl_hit;

   always_comb begin
      mode_ok    = 1'b1;
      wake_hit   = 1'b0;
      su_kind    = SU_NONE;
      sleep_gate = '0;
      case (mode)
         MD_IDLE: begin
            wake_hit                 = ext_any | wk_twi | wk_tmr | wk_adc | wk_io;
            sleep_gate.dom[DOM_IO]   = 1'b1;
            sleep_gate.dom[DOM_ADC]  = 1'b1;
            sleep_gate.dom[DOM_ASY]  = async_sel;
            sleep_gate.main_osc      = 1'b1;
            sleep_gate.tmr_osc       = async_sel;
         end
         MD_QADC: begin
            wake_hit                 = ext_lvl | wk_twi | (wk_tmr & async_sel) | wk_adc;
            sleep_gate.dom[DOM_ADC]  = 1'b1;
            sleep_gate.dom[DOM_ASY]  = async_sel;
            sleep_gate.main_osc      = 1'b1;
            sleep_gate.tmr_osc       = async_sel;
         end
         MD_PDOWN: begin
            wake_hit = ext_lvl | wk_twi;
            su_kind  = SU_PROG;
         end
         MD_PSAVE: begin
            wake_hit                 = ext_lvl | wk_twi | (wk_tmr & async_sel);
            su_kind                  = SU_PROG;
            sleep_gate.dom[DOM_ASY]  = async_sel;
            sleep_gate.tmr_osc       = async_sel;
         end
         MD_STBY: begin
            wake_hit            = ext_lvl | wk_twi;
            su_kind             = SU_FIXED;
            sleep_gate.main_osc = 1'b1;
         end
         default: mode_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
   import slp_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned HALT_CYCLES  = 4,
   parameter int unsigned STBY_STARTUP = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_go,
   input  logic             wake_hit,
   input  logic             rst_wake,
   input  slp_su_e          su_kind,
   input  logic [CNT_W-1:0] su_len,
   output slp_state_e       state_q,
   output slp_state_e       state_d,
   output logic             wake_irq,
   output logic             wake_reset
);

   localparam logic [CNT_W-1:0] HALT_LAST = CNT_W'(HALT_CYCLES - 1);
   localparam logic [CNT_W-1:0] STBY_LEN  = CNT_W'(STBY_STARTUP);

   logic [CNT_W-1:0] cnt_q, cnt_d, first_len;
   logic             rkind_q, rkind_d;
   logic             irq_p, rst_p;

   always_comb begin
      case (su_kind)
         SU_FIXED: first_len = STBY_LEN;
         SU_PROG:  first_len = su_len;
         default:  first_len = '0;
      endcase
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      rkind_d = rkind_q;
      irq_p   = 1'b0;
      rst_p   = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (sleep_go) begin
               state_d = ST_SLEEP;
               rkind_d = 1'b0;
            end
         end
         ST_SLEEP: begin
            if (rst_wake || wake_hit) begin
               rkind_d = rst_wake;
               if (first_len == '0) begin
                  state_d = ST_HALT;
                  cnt_d   = HALT_LAST;
               end else begin
                  state_d = ST_STARTUP;
                  cnt_d   = first_len - 1'b1;
               end
            end
         end
         ST_STARTUP: begin
            rkind_d = rkind_q | rst_wake;
            if (cnt_q == '0) begin
               state_d = ST_HALT;
               cnt_d   = HALT_LAST;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_HALT: begin
            rkind_d = rkind_q | rst_wake;
            if (cnt_q == '0) begin
               state_d = ST_RUN;
               irq_p   = ~rkind_d;
               rst_p   = rkind_d;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         cnt_q      <= '0;
         rkind_q    <= 1'b0;
         wake_irq   <= 1'b0;
         wake_reset <= 1'b0;
      end else begin
         state_q    <= state_d;
         cnt_q      <= cnt_d;
         rkind_q    <= rkind_d;
         wake_irq   <= irq_p;
         wake_reset <= rst_p;
      end
   end

endmodule

// File: rtl/slp_clkgate_ctrl.sv
module slp_clkgate_ctrl
   import slp_pkg::*;
#(
   parameter int unsigned N_EXT        = 2,
   parameter int unsigned STARTUP_W    = 8,
   parameter int unsigned HALT_CYCLES  = 4,
   parameter int unsigned STBY_STARTUP = 6,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_en,
   input  logic                 sleep_req,
   input  logic [2:0]           mode_sel,
   input  logic                 async_tmr_sel,
   input  logic [STARTUP_W-1:0] startup_len,
   input  logic [N_EXT-1:0]     ext_irq,
   input  logic [N_EXT-1:0]     ext_level,
   input  logic                 twi_match,
   input  logic                 tmr_async_irq,
   input  logic                 adc_irq,
   input  logic                 io_irq,
   input  logic                 rst_req,
   output logic [4:0]           clk_en,
   output logic                 osc_main_en,
   output logic                 osc_tmr_en,
   output logic                 core_halt,
   output logic                 wake_irq,
   output logic                 wake_reset
);

   localparam int unsigned WK_W  = N_EXT + NUM_SOLO;
   localparam int unsigned CNT_W = STARTUP_W;

   initial assert (N_EXT >= 1) else $fatal(1, "slp_clkgate_ctrl: N_EXT must be at least 1");
   initial assert (HALT_CYCLES >= 1) else $fatal(1, "slp_clkgate_ctrl: HALT_CYCLES must be at least 1");
   initial assert (STBY_STARTUP >= 1) else $fatal(1, "slp_clkgate_ctrl: STBY_STARTUP must be at least 1");
   initial assert ((1 << STARTUP_W) > HALT_CYCLES && (1 << STARTUP_W) > STBY_STARTUP)
      else $fatal(1, "slp_clkgate_ctrl: STARTUP_W too narrow for the fixed counts");

   // wake input synchronisation
   logic [WK_W-1:0] wk_raw, wk_s;
   assign wk_raw = {rst_req, io_irq, adc_irq, tmr_async_irq, twi_match, ext_irq};

   slp_wake_sync #(.WIDTH(WK_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (wk_raw),
      .dout (wk_s)
   );

   // mode latch
   slp_state_e             state_q, state_d;
   logic [2:0]             mode_q;
   logic                   async_q;
   logic [STARTUP_W-1:0]   len_q;
   logic                   in_run;
   logic [2:0]             mode_eff;
   logic                   async_eff;

   assign in_run    = (state_q == ST_RUN);
   assign mode_eff  = in_run ? mode_sel : mode_q;
   assign async_eff = in_run ? async_tmr_sel : async_q;

   logic       mode_ok, wake_hit, sleep_go;
   slp_su_e    su_kind;
   slp_gate_t  sleep_gate, run_gate, gate_d, gate_q;

   slp_mode_decode #(.N_EXT(N_EXT)) u_dec (
      .mode      (mode_eff),
      .async_sel (async_eff),
      .ext_level (ext_level),
      .wk_ext    (wk_s[N_EXT-1:0]),
      .wk_twi    (wk_s[N_EXT]),
      .wk_tmr    (wk_s[N_EXT+1]),
      .wk_adc    (wk_s[N_EXT+2]),
      .wk_io     (wk_s[N_EXT+3]),
      .mode_ok   (mode_ok),
      .wake_hit  (wake_hit),
      .su_kind   (su_kind),
      .sleep_gate(sleep_gate)
   );

   assign sleep_go = in_run & sleep_req & sleep_en & mode_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MD_IDLE;
         async_q <= 1'b0;
         len_q   <= '0;
      end else if (sleep_go) begin
         mode_q  <= mode_sel;
         async_q <= async_tmr_sel;
         len_q   <= startup_len;
      end
   end

   // sequencer
   slp_seq_fsm #(
      .CNT_W       (CNT_W),
      .HALT_CYCLES (HALT_CYCLES),
      .STBY_STARTUP(STBY_STARTUP)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_go  (sleep_go),
      .wake_hit  (wake_hit),
      .rst_wake  (wk_s[WK_W-1]),
      .su_kind   (su_kind),
      .su_len    (len_q),
      .state_q   (state_q),
      .state_d   (state_d),
      .wake_irq  (wake_irq),
      .wake_reset(wake_reset)
   );

   // registered gate enables, taken from the next state
   always_comb begin
      run_gate              = '0;
      run_gate.dom          = {async_tmr_sel, 4'b1111};
      run_gate.main_osc     = 1'b1;
      run_gate.tmr_osc      = async_tmr_sel;
      unique case (state_d)
         ST_RUN, ST_HALT: gate_d = run_gate;
         ST_SLEEP:        gate_d = sleep_gate;
         ST_STARTUP: begin
            gate_d          = sleep_gate;
            gate_d.main_osc = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q          <= '0;
         gate_q.dom      <= 5'b01111;
         gate_q.main_osc <= 1'b1;
      end else begin
         gate_q <= gate_d;
      end
   end

   assign clk_en      = gate_q.dom;
   assign osc_main_en = gate_q.main_osc;
   assign osc_tmr_en  = gate_q.tmr_osc;
   assign core_halt   = ~in_run;

endmodule

// File: rtl/slp_clkgate_chk.sv
module slp_clkgate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_en,
   input logic       sleep_req,
   input logic [4:0] clk_en,
   input logic       osc_main_en,
   input logic       core_halt,
   input logic       wake_irq,
   input logic       wake_reset
);

   // R1: disarmed request leaves the core running
   assert_no_sleep_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_halt && sleep_req && !sleep_en) |=> !core_halt);

   // R3: CPU clock is only stopped while the core is parked
   assert_cpu_gate_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en[0] |-> core_halt);

   // R4: synchronous domains are dark whenever the main oscillator is off
   assert_osc_off_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_main_en |-> (clk_en[3:0] == 4'b0000));

   // R9: the two wake pulses never coincide
   assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_irq && wake_reset));

   // R9: a pulse lasts a single cycle
   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_irq || wake_reset) |=> !(wake_irq || wake_reset));

   // R9: every return to running carries exactly one pulse
   assert_exit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_halt) |-> (wake_irq || wake_reset));

   // R8: the halt stretch keeps all synchronous clocks on before release
   assert_halt_clocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_irq || wake_reset) |-> $past(clk_en[3:0] == 4'b1111));

endmodule

bind slp_clkgate_ctrl slp_clkgate_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep_en   (sleep_en),
   .sleep_req  (sleep_req),
   .clk_en     (clk_en),
   .osc_main_en(osc_main_en),
   .core_halt  (core_halt),
   .wake_irq   (wake_irq),
   .wake_reset (wake_reset)
);

// File: tb/test_slp_clkgate_ctrl.sv
module test_slp_clkgate_ctrl;

   localparam int NE  = 2;
   localparam int SW  = 8;
   localparam int WKW = NE + 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_en = 1'b0, sleep_req = 1'b0;
   logic [2:0]    mode_sel = 3'b000;
   logic          async_tmr_sel = 1'b0;
   logic [SW-1:0] startup_len = '0;
   logic [NE-1:0] ext_irq = '0, ext_level = '0;
   logic          twi_match = 1'b0, tmr_async_irq = 1'b0, adc_irq = 1'b0, io_irq = 1'b0, rst_req = 1'b0;
   logic [4:0]    clk_en;
   logic          osc_main_en, osc_tmr_en, core_halt, wake_irq, wake_reset;

   slp_clkgate_ctrl i_slp_clkgate_ctrl (.*);

   always #4 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   string tag = "R3";
   bit cmp_on = 0;

   // ---------------- behavioural reference ----------------
   int         m_st = 0, m_cnt = 0, m_mode = 0, m_len = 0;
   bit         m_async = 0, m_rk = 0;
   logic [WKW-1:0] q_a = '0, q_b = '0;
   logic [4:0] e_clk = 5'b01111;
   bit         e_main = 1, e_tmr = 0, e_wi = 0, e_wr = 0;

   function automatic bit legal(logic [2:0] m);
      return m inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110};
   endfunction

   function automatic bit accepts(int md, bit as, logic [WKW-1:0] v, logic [NE-1:0] lv);
      bit lvl = |(v[NE-1:0] & lv);
      bit twi = v[NE], tmr = v[NE+1], adc = v[NE+2], io = v[NE+3];
      case (md)
         0: return (|v[NE-1:0]) | twi | tmr | adc | io;
         1: return lvl | twi | (tmr & as) | adc;
         3: return lvl | twi | (tmr & as);
         default: return lvl | twi;
      endcase
   endfunction

   function automatic int su_cycles(int md, int len);
      if (md == 2 || md == 3) return len;
      if (md == 6) return 6;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_rk = 0; q_a = '0; q_b = '0;
         e_clk = 5'b01111; e_main = 1; e_tmr = 0; e_wi = 0; e_wr = 0;
      end else begin
         bit rw, hit;
         rw  = q_b[WKW-1];
         hit = accepts(m_mode, m_async, q_b, ext_level);
         e_wi = 0; e_wr = 0;
         case (m_st)
            0: if (sleep_req && sleep_en && legal(mode_sel)) begin
                  m_st = 1; m_mode = int'(mode_sel); m_async = async_tmr_sel;
                  m_len = int'(startup_len); m_rk = 0;
               end
            1: if (rw || hit) begin
                  m_rk = rw;
                  if (su_cycles(m_mode, m_len) == 0) begin m_st = 3; m_cnt = 4; end
                  else begin m_st = 2; m_cnt = su_cycles(m_mode, m_len); end
               end
            2: begin
                  m_rk = m_rk | rw; m_cnt--;
                  if (m_cnt == 0) begin m_st = 3; m_cnt = 4; end
               end
            default: begin
                  m_rk = m_rk | rw; m_cnt--;
                  if (m_cnt == 0) begin
                     m_st = 0;
                     if (m_rk) e_wr = 1; else e_wi = 1;
                  end
               end
         endcase
         q_b = q_a;
         q_a = {rst_req, io_irq, adc_irq, tmr_async_irq, twi_match, ext_irq};
         if (m_st == 0 || m_st == 3) begin
            e_clk = {async_tmr_sel, 4'b1111}; e_main = 1; e_tmr = async_tmr_sel;
         end else begin
            case (m_mode)
               0: begin e_clk = {m_async, 4'b1100}; e_main = 1; end
               1: begin e_clk = {m_async, 4'b1000}; e_main = 1; end
               3: begin e_clk = {m_async, 4'b0000}; e_main = 0; end
               6: begin e_clk = 5'b0; e_main = 1; end
               default: begin e_clk = 5'b0; e_main = 0; end
            endcase
            e_tmr = e_clk[4];
            if (m_st == 2) e_main = 1;
         end
      end
   end

   // ---------------- comparison ----------------
   task automatic chk(string req, string what, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R3", "clk_en", int'(clk_en), int'(e_clk));
         chk("R4", "osc_main_en", int'(osc_main_en), int'(e_main));
         chk("R4", "osc_tmr_en", int'(osc_tmr_en), int'(e_tmr));
         chk(tag, "core_halt", int'(core_halt), int'(m_st != 0));
         chk("R9", "wake_irq", int'(wake_irq), int'(e_wi));
         chk("R10", "wake_reset", int'(wake_reset), int'(e_wr));
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         finish_run();
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_sleep(logic [2:0] m, logic as, int len);
      mode_sel = m; async_tmr_sel = as; startup_len = SW'(len);
      sleep_en = 1; sleep_req = 1;
      tick(1);
      sleep_req = 0;
      tick(1);
   endtask

   task automatic clear_src();
      ext_irq = '0; twi_match = 0; tmr_async_irq = 0; adc_irq = 0; io_irq = 0; rst_req = 0;
   endtask

   task automatic wait_run();
      for (int i = 0; i < 400 && core_halt; i++) tick(1);
      tick(1);
      clear_src();
      tick(3);
   endtask

   initial begin
      tick(2);
      // reset state, R3 and R4
      chk("R3", "reset clk_en", int'(clk_en), 'h0f);
      chk("R4", "reset osc_main_en", int'(osc_main_en), 1);
      chk("R9", "reset core_halt", int'(core_halt), 0);
      rst_n = 1;
      cmp_on = 1;
      tick(2);

      // R1: disarmed request
      tag = "R1";
      mode_sel = 3'b010; sleep_en = 0; sleep_req = 1; tick(1); sleep_req = 0; tick(3);
      chk("R1", "core_halt disarmed", int'(core_halt), 0);

      // R2: reserved codes
      tag = "R2";
      for (int c = 4; c < 8; c++) begin
         if (c == 6) continue;
         go_sleep(3'(c), 0, 0);
         tick(2);
         chk("R2", "core_halt reserved code", int'(core_halt), 0);
      end

      // R11 + R5: idle, I/O interrupt, latency
      tag = "R11";
      go_sleep(3'b000, 0, 0);
      chk("R3", "idle clk_en", int'(clk_en), 'h0c);
      io_irq = 1;
      tick(6);
      chk("R11", "still halted before release", int'(core_halt), 1);
      tick(1);
      chk("R11", "wake_irq after six edges", int'(wake_irq), 1);
      wait_run();

      // R5: quiet-ADC ignores I/O, accepts ADC
      tag = "R5";
      go_sleep(3'b001, 0, 0);
      io_irq = 1; tick(8);
      chk("R5", "quiet-ADC ignores io_irq", int'(core_halt), 1);
      io_irq = 0; adc_irq = 1;
      wait_run();

      // R7: quiet-ADC timer needs async latched
      tag = "R7";
      go_sleep(3'b001, 0, 0);
      tmr_async_irq = 1; tick(8);
      chk("R7", "timer ignored without async", int'(core_halt), 1);
      tmr_async_irq = 0; adc_irq = 1;
      wait_run();
      go_sleep(3'b001, 1, 0);
      tmr_async_irq = 1;
      wait_run();

      // R6: power-down, edge line ignored, level line wakes, start-up 3 (R8)
      tag = "R6";
      ext_level = 2'b10;
      go_sleep(3'b010, 0, 3);
      chk("R3", "power-down clk_en", int'(clk_en), 0);
      chk("R4", "power-down main osc", int'(osc_main_en), 0);
      ext_irq = 2'b01; io_irq = 1; tick(10);
      chk("R6", "edge line ignored", int'(core_halt), 1);
      ext_irq = 2'b10; io_irq = 0;
      wait_run();

      // R8: zero start-up length in power-down
      tag = "R8";
      go_sleep(3'b010, 0, 0);
      twi_match = 1;
      wait_run();

      // R7: power-save with async, timer wakes; without async, serial match wakes
      tag = "R7";
      go_sleep(3'b011, 1, 5);
      chk("R3", "power-save clk_en", int'(clk_en), 'h10);
      tmr_async_irq = 1;
      wait_run();
      go_sleep(3'b011, 0, 2);
      tmr_async_irq = 1; tick(8);
      chk("R7", "power-save timer ignored", int'(core_halt), 1);
      tmr_async_irq = 0; twi_match = 1;
      wait_run();

      // R8: standby fixed start-up, main osc kept
      tag = "R8";
      go_sleep(3'b110, 0, 40);
      chk("R4", "standby main osc", int'(osc_main_en), 1);
      ext_irq = 2'b10;
      wait_run();

      // R12-style latching (R7): changes while asleep have no effect
      tag = "R7";
      go_sleep(3'b010, 0, 2);
      mode_sel = 3'b000; async_tmr_sel = 1; startup_len = 8'd9;
      sleep_req = 1; tick(1); sleep_req = 0;
      io_irq = 1; tick(8);
      chk("R7", "latched mode kept", int'(core_halt), 1);
      io_irq = 0; twi_match = 1;
      wait_run();
      async_tmr_sel = 0; tick(2);

      // R10: reset request alone, with an interrupt, and during halt
      tag = "R10";
      go_sleep(3'b010, 0, 4);
      rst_req = 1;
      wait_run();
      go_sleep(3'b000, 0, 0);
      rst_req = 1; io_irq = 1;
      wait_run();
      go_sleep(3'b000, 0, 0);
      io_irq = 1; tick(3);
      rst_req = 1;
      for (int i = 0; i < 20 && !wake_reset && !wake_irq; i++) tick(1);
      chk("R10", "late reset upgrades pulse", int'(wake_reset), 1);
      wait_run();

      tick(4);
      finish_run();
   end

endmodule